// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps a 32-bit processor address onto one of ten programmable address windows, or onto a small fixed-size internal register window. It produces a one-hot select, a decode-miss flag and a translated outgoing address. Four windows serve device chip-select groups. The other six serve the I/O, memory-0 and memory-1 spaces of two PCI buses (indices 4..6 for the first bus, 7..9 for the second). Every window is built from 2 MB granules. It is defined by a low-decode register, a high-decode register and a remap register, and the remap register supplies the upper address bits of the translated address.

Configuration is written through a one-cycle register write port. Decoding is combinational from the registered configuration, so a lookup completes in the same cycle the address is presented. Two fixed reserved address holes are clipped out of every window, including the internal one.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every programmable window is disabled: high-decode is 0 and low-decode is 0x0001. The internal register window sits at base granule 0x0DF (address 0x1BE0_0000), and the remap registers are 0.
- R2: A write with `cfg_kind` = 0 (low-decode) to window `cfg_idx` keeps `cfg_wdata[14:0]` as low-decode. The same write loads that window's remap register with `cfg_wdata[10:0]`.
- R3: A write with `cfg_kind` = 1 (high-decode) keeps `cfg_wdata[6:0]`. A write with `cfg_kind` = 2 (remap) keeps `cfg_wdata[10:0]`. A write with `cfg_kind` = 3 sets the internal window base from `cfg_wdata[14:0]` and ignores `cfg_idx`.
- R4: A window is enabled only when low-decode[6:0] <= high-decode. When enabled, it covers granules from low-decode (all 15 bits) up to, but not including, low-decode + high-decode + 1 − low-decode[6:0]. A granule is the address shifted right by 21.
- R5: For a device or memory window hit, `xlat_addr` is the remap value in bits [31:21] and `cpu_addr[20:0]` below.
- R6: For a hit on a PCI I/O window (indices 4 and 7), `xlat_addr` is `cpu_addr[15:0]` zero-extended.
- R7: The internal window is 4 KB long and starts at its base value shifted left by 21. A hit sets `win_sel[10]`, and `xlat_addr` is `cpu_addr[11:0]` zero-extended.
- R8: Addresses 0x1E00_0000..0x1F0F_FFFF and 0x1FC0_0000..0x1FCF_FFFF never hit any window.
- R9: The internal window beats every programmable window, and a lower window index beats a higher one. `win_sel` is always one-hot or zero.
- R10: When no window hits, `win_miss` is 1, and both `win_sel` and `xlat_addr` are 0.
- R11: A configuration write changes decode results from the cycle after the clock edge that accepts it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 0 low, 1 high, 2 remap, 3 internal base |
| cfg_idx | input | 4 | Window index 0..9 |
| cfg_wdata | input | 32 | Write data |
| cpu_addr | input | 32 | Address to decode |
| win_sel | output | 11 | One-hot select; bits 0..9 windows, bit 10 internal |
| win_miss | output | 1 | No window hit |
| xlat_addr | output | 32 | Translated address |

## Verification
A wrong stored configuration shows up at the ports in the same cycle a matching address is presented, because decode is combinational. The symptom is a select bit on the wrong window or a miss where a hit was due. A corrupted remap register leaves the select correct but changes only `xlat_addr[31:21]`, so translated addresses are compared in full. A write that lands early or late shows up as a changed or unchanged select on the cycle either side of the accepting edge. Granule boundaries, overlaps and hole edges are probed to catch off-by-one errors in the range arithmetic.

// File: rtl/awd_pkg.sv
// Package: shared encodings for the address window decoder.
// Assumes: register kinds are fixed by the write-port contract.
package awd_pkg;
    typedef enum logic [1:0] {
        CFG_LOW    = 2'd0,
        CFG_HIGH   = 2'd1,
        CFG_REMAP  = 2'd2,
        CFG_ISPACE = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/awd_cfg_regs.sv
// Module: configuration register file for all windows plus the internal base.
// Masks each write to its field width; a low-decode write also loads remap.
// Assumes: idx values >= NUM_WIN are ignored; internal base write ignores idx.
module awd_cfg_regs #(
    parameter int NUM_WIN  = 10,
    parameter int IDX_W    = 4,
    parameter int DATA_W   = 32,
    parameter int LO_W     = 15,
    parameter int HI_W     = 7,
    parameter int RM_W     = 11,
    parameter logic [LO_W-1:0] LO_RST  = 15'h0001,
    parameter logic [LO_W-1:0] ISP_RST = 15'h00DF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [1:0]                    kind,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_WIN-1:0][LO_W-1:0]  lo_q,
    output logic [NUM_WIN-1:0][HI_W-1:0]  hi_q,
    output logic [NUM_WIN-1:0][RM_W-1:0]  rm_q,
    output logic [LO_W-1:0]               isp_q
);
    import awd_pkg::*;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:LO_W];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Per-window register update with field masking
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[w] <= LO_RST;
                hi_q[w] <= '0;
                rm_q[w] <= '0;
            end else if (we && idx == IDX_W'(w)) begin
                case (cfg_kind_e'(kind))
                    CFG_LOW: begin
                        lo_q[w] <= wdata[LO_W-1:0];
                        rm_q[w] <= wdata[RM_W-1:0];
                    end
                    CFG_HIGH:  hi_q[w] <= wdata[HI_W-1:0];
                    CFG_REMAP: rm_q[w] <= wdata[RM_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // Internal register window base update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isp_q <= ISP_RST;
        end else if (we && cfg_kind_e'(kind) == CFG_ISPACE) begin
            isp_q <= wdata[LO_W-1:0];
        end
    end
endmodule

// File: rtl/awd_win_match.sv
// Module: range match of one address granule against one window.
// Enabled when low[HI_W-1:0] <= high; covers granules [low, low+high+1-low[HI_W-1:0]).
// Assumes: gran is the address shifted right by the granule size.
module awd_win_match #(
    parameter int LO_W = 15,
    parameter int HI_W = 7,
    parameter int GR_W = 11
) (
    input  logic [LO_W-1:0] lo,
    input  logic [HI_W-1:0] hi,
    input  logic [GR_W-1:0] gran,
    output logic            hit
);
    localparam int CW = LO_W + 2;

    logic [HI_W-1:0] lo_low;
    logic            en;
    logic [CW-1:0]   start_g;
    logic [CW-1:0]   end_g;
    logic [CW-1:0]   gran_x;

    // Enable check and granule window bounds
    always_comb begin
        lo_low  = lo[HI_W-1:0];
        en      = (lo_low <= hi);
        start_g = CW'(lo);
        end_g   = CW'(lo) + CW'(hi) + CW'(1) - CW'(lo_low);
        gran_x  = CW'(gran);
        hit     = en && (gran_x >= start_g) && (gran_x < end_g);
    end
endmodule

// File: rtl/awd_select.sv
// Module: priority pick among window hits and address translation.
// Internal window first, then lowest index; holes suppress every hit.
// Assumes: IO_MASK marks the windows that forward a 16-bit port address.
module awd_select #(
    parameter int NUM_WIN   = 10,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAN_SH   = 21,
    parameter int INT_SH    = 12,
    parameter int IO_W      = 16,
    parameter logic [NUM_WIN-1:0] IO_MASK = 10'h090
) (
    input  logic [NUM_WIN-1:0]                         win_hit,
    input  logic                                       int_hit,
    input  logic                                       hole,
    input  logic [ADDR_W-1:0]                          addr,
    input  logic [NUM_WIN-1:0][ADDR_W-GRAN_SH-1:0]     rm,
    output logic [NUM_WIN:0]                           sel,
    output logic                                       miss,
    output logic [ADDR_W-1:0]                          xlat
);
    logic [IDX_W-1:0] pick;
    logic             any;

    // Lowest-index programmable hit
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                pick = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    // Final select and translated address
    always_comb begin
        sel  = '0;
        xlat = '0;
        if (!hole) begin
            if (int_hit) begin
                sel[NUM_WIN] = 1'b1;
                xlat = ADDR_W'(addr[INT_SH-1:0]);
            end else if (any) begin
                sel[pick] = 1'b1;
                if (IO_MASK[pick]) begin
                    xlat = ADDR_W'(addr[IO_W-1:0]);
                end else begin
                    xlat = {rm[pick], addr[GRAN_SH-1:0]};
                end
            end
        end
        miss = ~|sel;
    end
endmodule

// File: rtl/addr_window_decoder.sv
// Module: top of the programmable address window decoder.
// Registered configuration, combinational decode of cpu_addr.
// Assumes: ADDR_W - GRAN_SH equals the remap width; holes are fixed constants.
module addr_window_decoder #(
    parameter int NUM_WIN  = 10,
    parameter int ADDR_W   = 32,
    parameter int GRAN_SH  = 21,
    parameter int INT_SH   = 12,
    parameter int IO_W     = 16,
    parameter int LO_W     = 15,
    parameter int HI_W     = 7,
    parameter logic [NUM_WIN-1:0] IO_MASK = 10'h090,
    parameter logic [LO_W-1:0]    LO_RST  = 15'h0001,
    parameter logic [LO_W-1:0]    ISP_RST = 15'h00DF,
    parameter logic [ADDR_W-1:0]  HOLE0_LO = 32'h1E00_0000,
    parameter logic [ADDR_W-1:0]  HOLE0_HI = 32'h1F0F_FFFF,
    parameter logic [ADDR_W-1:0]  HOLE1_LO = 32'h1FC0_0000,
    parameter logic [ADDR_W-1:0]  HOLE1_HI = 32'h1FCF_FFFF,
    localparam int IDX_W = $clog2(NUM_WIN),
    localparam int RM_W  = ADDR_W - GRAN_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [NUM_WIN:0]  win_sel,
    output logic              win_miss,
    output logic [ADDR_W-1:0] xlat_addr
);
    logic [NUM_WIN-1:0][LO_W-1:0] lo_q;
    logic [NUM_WIN-1:0][HI_W-1:0] hi_q;
    logic [NUM_WIN-1:0][RM_W-1:0] rm_q;
    logic [LO_W-1:0]              isp_q;
    logic [NUM_WIN-1:0]           win_hit;
    logic [RM_W-1:0]              gran;
    logic                         int_hit;
    logic                         hole;

    assign gran = cpu_addr[ADDR_W-1:GRAN_SH];

    awd_cfg_regs #(
        .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .DATA_W(ADDR_W), .LO_W(LO_W),
        .HI_W(HI_W), .RM_W(RM_W), .LO_RST(LO_RST), .ISP_RST(ISP_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind),
        .idx(cfg_idx), .wdata(cfg_wdata),
        .lo_q(lo_q), .hi_q(hi_q), .rm_q(rm_q), .isp_q(isp_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        awd_win_match #(.LO_W(LO_W), .HI_W(HI_W), .GR_W(RM_W)) u_match (
            .lo(lo_q[w]), .hi(hi_q[w]), .gran(gran), .hit(win_hit[w])
        );
    end

    // Internal 4 KB window and reserved-hole detection
    always_comb begin
        int_hit = (LO_W'(gran) == isp_q) && (cpu_addr[GRAN_SH-1:INT_SH] == '0);
        hole    = ((cpu_addr >= HOLE0_LO) && (cpu_addr <= HOLE0_HI)) ||
                  ((cpu_addr >= HOLE1_LO) && (cpu_addr <= HOLE1_HI));
    end

    awd_select #(
        .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .GRAN_SH(GRAN_SH),
        .INT_SH(INT_SH), .IO_W(IO_W), .IO_MASK(IO_MASK)
    ) u_sel (
        .win_hit(win_hit), .int_hit(int_hit), .hole(hole), .addr(cpu_addr),
        .rm(rm_q), .sel(win_sel), .miss(win_miss), .xlat(xlat_addr)
    );
endmodule

// File: rtl/awd_checker.sv
// Module: property checker for the address window decoder, bound to the top.
// Assumes: observes ports only; hole bounds and IO_MASK passed from the top.
module awd_checker #(
    parameter int NUM_WIN = 10,
    parameter int ADDR_W  = 32,
    parameter logic [NUM_WIN-1:0] IO_MASK = 10'h090,
    parameter logic [ADDR_W-1:0]  HOLE0_LO = 32'h1E00_0000,
    parameter logic [ADDR_W-1:0]  HOLE0_HI = 32'h1F0F_FFFF,
    parameter logic [ADDR_W-1:0]  HOLE1_LO = 32'h1FC0_0000,
    parameter logic [ADDR_W-1:0]  HOLE1_HI = 32'h1FCF_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [NUM_WIN:0]  win_sel,
    input logic              win_miss,
    input logic [ADDR_W-1:0] xlat_addr
);
    logic in_hole;
    logic io_hit;
    logic mem_hit;
    assign in_hole = ((cpu_addr >= HOLE0_LO) && (cpu_addr <= HOLE0_HI)) ||
                     ((cpu_addr >= HOLE1_LO) && (cpu_addr <= HOLE1_HI));
    assign io_hit  = |(win_sel[NUM_WIN-1:0] & IO_MASK);
    assign mem_hit = |(win_sel[NUM_WIN-1:0] & ~IO_MASK);

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));

    assert_miss_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> (win_sel == '0 && xlat_addr == '0));

    assert_hole_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_hole |-> win_miss);

    assert_io_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (xlat_addr[ADDR_W-1:16] == '0 && xlat_addr[15:0] == cpu_addr[15:0]));

    assert_int_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel[NUM_WIN] |-> (xlat_addr[ADDR_W-1:12] == '0 && xlat_addr[11:0] == cpu_addr[11:0]));

    assert_mem_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (xlat_addr[20:0] == cpu_addr[20:0]));

    assert_no_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(cpu_addr)) |-> $stable(win_sel));
endmodule

bind addr_window_decoder awd_checker #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IO_MASK(IO_MASK),
    .HOLE0_LO(HOLE0_LO), .HOLE0_HI(HOLE0_HI),
    .HOLE1_LO(HOLE1_LO), .HOLE1_HI(HOLE1_HI)
) u_awd_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cpu_addr(cpu_addr),
    .win_sel(win_sel), .win_miss(win_miss), .xlat_addr(xlat_addr)
);

// File: tb/test_addr_window_decoder.sv
// Bench: vector table walked by one loop, then directed reset and timing tests.
module test_addr_window_decoder;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic        we;
        logic [1:0]  kind;
        logic [3:0]  idx;
        logic [31:0] wdata;
        logic [31:0] addr;
        logic [10:0] esel;
        logic        emiss;
        logic [31:0] eout;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t TBL [NV] = '{
        '{1'b0,2'd0,4'd0,32'h0,        32'h1BE0_0010,11'h400,1'b0,32'h0000_0010,4'd1}, // R1 internal at reset base
        '{1'b0,2'd0,4'd0,32'h0,        32'h1BE0_1000,11'h000,1'b1,32'h0,        4'd7}, // R7 past 4 KB
        '{1'b0,2'd0,4'd0,32'h0,        32'h0000_0000,11'h000,1'b1,32'h0,        4'd1}, // R1 windows off
        '{1'b1,2'd0,4'd0,32'h1234_8004,32'h0,        11'h000,1'b0,32'h0,        4'd2}, // R2 lo win0
        '{1'b1,2'd1,4'd0,32'h0000_0F85,32'h0,        11'h000,1'b0,32'h0,        4'd3}, // R3 hi win0 = 5
        '{1'b0,2'd0,4'd0,32'h0,        32'h0080_0123,11'h001,1'b0,32'h0080_0123,4'd4}, // R4 first granule
        '{1'b0,2'd0,4'd0,32'h0,        32'h00BF_FFFC,11'h001,1'b0,32'h009F_FFFC,4'd4}, // R4 last granule, R2 remap
        '{1'b0,2'd0,4'd0,32'h0,        32'h00C0_0000,11'h000,1'b1,32'h0,        4'd4}, // R4 one past
        '{1'b0,2'd0,4'd0,32'h0,        32'h007F_FFFF,11'h000,1'b1,32'h0,        4'd4}, // R4 one below
        '{1'b1,2'd2,4'd0,32'hFFFF_F855,32'h0,        11'h000,1'b0,32'h0,        4'd3}, // R3 remap masked
        '{1'b0,2'd0,4'd0,32'h0,        32'h00A0_0010,11'h001,1'b0,32'h0AA0_0010,4'd5}, // R5 remap
        '{1'b1,2'd0,4'd4,32'h0000_0010,32'h0,        11'h000,1'b0,32'h0,        4'd6},
        '{1'b1,2'd1,4'd4,32'h0000_0010,32'h0,        11'h000,1'b0,32'h0,        4'd6},
        '{1'b0,2'd0,4'd0,32'h0,        32'h0213_ABCD,11'h010,1'b0,32'h0000_ABCD,4'd6}, // R6 io port
        '{1'b1,2'd0,4'd5,32'h0000_0010,32'h0,        11'h000,1'b0,32'h0,        4'd9},
        '{1'b1,2'd1,4'd5,32'h0000_0011,32'h0,        11'h000,1'b0,32'h0,        4'd9},
        '{1'b0,2'd0,4'd0,32'h0,        32'h0200_0004,11'h010,1'b0,32'h0000_0004,4'd9}, // R9 lower index wins
        '{1'b0,2'd0,4'd0,32'h0,        32'h0220_0008,11'h020,1'b0,32'h0200_0008,4'd5}, // R5 win5
        '{1'b1,2'd0,4'd9,32'h0000_00DF,32'h0,        11'h000,1'b0,32'h0,        4'd9},
        '{1'b1,2'd1,4'd9,32'h0000_00DF,32'h0,        11'h000,1'b0,32'h0,        4'd9},
        '{1'b0,2'd0,4'd0,32'h0,        32'h1BE0_0020,11'h400,1'b0,32'h0000_0020,4'd9}, // R9 internal wins
        '{1'b0,2'd0,4'd0,32'h0,        32'h1BE0_1000,11'h200,1'b0,32'h1BE0_1000,4'd9}, // R9 win9 outside 4 KB
        '{1'b1,2'd0,4'd2,32'h0000_00F0,32'h0,        11'h000,1'b0,32'h0,        4'd8},
        '{1'b1,2'd1,4'd2,32'h0000_00FE,32'h0,        11'h000,1'b0,32'h0,        4'd8},
        '{1'b0,2'd0,4'd0,32'h0,        32'h1E10_0000,11'h000,1'b1,32'h0,        4'd8}, // R8 hole 0
        '{1'b0,2'd0,4'd0,32'h0,        32'h1E00_0000,11'h000,1'b1,32'h0,        4'd8}, // R8 hole 0 start
        '{1'b0,2'd0,4'd0,32'h0,        32'h1F0F_FFFF,11'h000,1'b1,32'h0,        4'd8}, // R8 hole 0 end
        '{1'b0,2'd0,4'd0,32'h0,        32'h1F10_0000,11'h004,1'b0,32'h1E10_0000,4'd8}, // R8 after hole 0
        '{1'b0,2'd0,4'd0,32'h0,        32'h1FBF_FFFF,11'h004,1'b0,32'h1E1F_FFFF,4'd8}, // R8 before hole 1
        '{1'b0,2'd0,4'd0,32'h0,        32'h1FC0_0000,11'h000,1'b1,32'h0,        4'd8}, // R8 hole 1 start
        '{1'b0,2'd0,4'd0,32'h0,        32'h1FCF_FFFF,11'h000,1'b1,32'h0,        4'd8}, // R8 hole 1 end
        '{1'b0,2'd0,4'd0,32'h0,        32'h1FD0_0000,11'h004,1'b0,32'h1E10_0000,4'd8}, // R8 after hole 1
        '{1'b1,2'd3,4'd6,32'h0001_8010,32'h0,        11'h000,1'b0,32'h0,        4'd7}, // R3 internal base write
        '{1'b0,2'd0,4'd0,32'h0,        32'h0200_0FFF,11'h400,1'b0,32'h0000_0FFF,4'd7}, // R7 moved internal
        '{1'b0,2'd0,4'd0,32'h0,        32'h0200_1000,11'h010,1'b0,32'h0000_1000,4'd7}, // R7 end of 4 KB
        '{1'b0,2'd0,4'd0,32'h0,        32'h1BE0_0010,11'h200,1'b0,32'h1BE0_0010,4'd7}, // R7 old base freed
        '{1'b0,2'd0,4'd0,32'h0,        32'h0080_0000,11'h001,1'b0,32'h0AA0_0000,4'd3}, // R3 idx ignored for base
        '{1'b1,2'd0,4'd1,32'h0000_0030,32'h0,        11'h000,1'b0,32'h0,        4'd4},
        '{1'b1,2'd1,4'd1,32'h0000_0020,32'h0,        11'h000,1'b0,32'h0,        4'd4},
        '{1'b0,2'd0,4'd0,32'h0,        32'h0600_0000,11'h000,1'b1,32'h0,        4'd4}, // R4 lo > hi disabled
        '{1'b1,2'd0,4'd3,32'h0000_0801,32'h0,        11'h000,1'b0,32'h0,        4'd4},
        '{1'b1,2'd1,4'd3,32'h0000_0001,32'h0,        11'h000,1'b0,32'h0,        4'd4},
        '{1'b0,2'd0,4'd0,32'h0,        32'h0020_0000,11'h000,1'b1,32'h0,        4'd4}, // R4 full 15-bit start
        '{1'b0,2'd0,4'd0,32'h0,        32'h0000_0000,11'h000,1'b1,32'h0,        4'd10} // R10 miss
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cpu_addr = '0;
    logic [10:0] win_sel;
    logic        win_miss;
    logic [31:0] xlat_addr;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr),
        .win_sel(win_sel), .win_miss(win_miss), .xlat_addr(xlat_addr)
    );

    task automatic check(input int tag, input logic [10:0] esel,
                         input logic emiss, input logic [31:0] eout);
        n_run++;
        if (win_sel !== esel || win_miss !== emiss || xlat_addr !== eout) begin
            n_fail++;
            $display("FAIL R%0d addr=%h actual sel=%h miss=%b out=%h expected sel=%h miss=%b out=%h",
                     tag, cpu_addr, win_sel, win_miss, xlat_addr, esel, emiss, eout);
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Table walk: writes land at the next edge, decodes sampled mid-cycle
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cfg_we    = TBL[k].we;
            cfg_kind  = TBL[k].kind;
            cfg_idx   = TBL[k].idx;
            cfg_wdata = TBL[k].wdata;
            if (!TBL[k].we) begin
                cpu_addr = TBL[k].addr;
                #1;
                check(int'(TBL[k].tag), TBL[k].esel, TBL[k].emiss, TBL[k].eout);
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;

        // R1: reset restores disabled windows and the internal base
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 32'h1BE0_0010;
        #1 check(1, 11'h400, 1'b0, 32'h0000_0010);  // R1
        cpu_addr = 32'h0080_0123;
        #1 check(1, 11'h000, 1'b1, 32'h0);          // R1
        cpu_addr = 32'h0200_0FFF;
        #1 check(1, 11'h000, 1'b1, 32'h0);          // R1 moved base undone

        // R11: write visible only after the accepting edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'd1; cfg_idx = 4'd0; cfg_wdata = 32'h5;
        cpu_addr = 32'h0020_0044;
        #1 check(11, 11'h000, 1'b1, 32'h0);         // R11 before edge
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check(11, 11'h001, 1'b0, 32'h0000_0044); // R11 after edge
        cpu_addr = 32'h00C0_0000;
        #1 check(4, 11'h000, 1'b1, 32'h0);          // R4 reset lo=1, hi=5 ends at granule 5

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule